// File: doc/BRIEF.md
# System Clock Frequency Classifier

This block works out which of six standard crystal frequencies drives the system clock. It does so by comparing the system clock against a slow reference clock of about 32 kHz whose frequency is known. A free-running tick counter runs on the system clock. The reference clock passes through a synchroniser into the system-clock domain, and the block counts its rising edges.

Each measurement is launched by a start pulse and runs in two phases. First the block lets a number of reference periods go by as settling time, then it latches the tick count. It then counts ticks over a further fixed number of reference periods. The tick difference may be doubled when the oscillator is pre-divided, and it is then checked against an ordered set of thresholds.

The results stay on the outputs until the next measurement finishes, and a one-cycle done pulse marks the cycle in which they change. There are five results:
- a class code;
- the input-select code that clock configuration needs;
- the choice of input divider;
- a parameter-table index;
- a flag that asks for a secondary divider to be cleared.

Top module: `clk_class_gauge`

## Requirements
- R1: After an accepted start, the base tick count is taken on the SETTLE_PERIODS-th synchronised rising edge of the reference clock. No result can appear sooner than (SETTLE_PERIODS+WINDOW_PERIODS-1) reference periods after start.
- R2: The measured count is the tick count at the WINDOW_PERIODS-th rising edge after the base edge, minus the base count, taken modulo 2^CNT_W. For a reference period of P ticks it equals WINDOW_PERIODS*P.
- R3: When prediv2_i is 1 in the cycle the window closes, the count is doubled before it is classified.
- R4: The class is chosen by strict comparisons, checked in this order: above 19000 gives 38.4 MHz (class_o=5), above 15200 gives 26 MHz (4), above 13000 gives 24 MHz (3), above 9000 gives 19.2 MHz (2), above 7600 gives 13 MHz (1). Any other count gives 12 MHz (0).
- R5: sel_o is 4 for 38.4 MHz, 3 for 26 MHz, 2 for 19.2 MHz and 1 for 13 MHz. For 12 MHz and for 24 MHz it is 0.
- R6: If sel_o is greater than 2, div2_o is 1 and index_o is sel_o/2. Otherwise div2_o is 0 and index_o equals sel_o.
- R7: clr_aux_div_o is 1 exactly when sel_o is not 1.
- R8: done_o is high for exactly one cycle per measurement, and the result outputs change only in that cycle.
- R9: A start pulse while a measurement is in progress is ignored. The running measurement neither restarts nor lengthens.
- R10: After reset, done_o is 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock being classified |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Slow reference clock, asynchronous |
| start_i | input | 1 | Launches a measurement when idle |
| prediv2_i | input | 1 | Oscillator is pre-divided by 2 |
| done_o | output | 1 | One-cycle pulse when results update |
| class_o | output | 3 | Frequency class code (R4) |
| sel_o | output | 3 | Input-select code (R5) |
| div2_o | output | 1 | Use divide-by-2 input divider (R6) |
| index_o | output | 2 | Parameter-table index (R6) |
| clr_aux_div_o | output | 1 | Clear the secondary input divider (R7) |

## Verification
Several properties are checked by the assertions on every cycle:
- the synchronised edge is a single-cycle pulse;
- a start arriving during a measurement leaves the controller's state and edge count untouched;
- done_o is a single-cycle pulse;
- the result outputs stay constant outside done;
- the divider, index and clear flags agree with the select code.

Other behaviours can only be shown by the bench's scenarios, because they depend on a reference period it chooses:
- the actual tick arithmetic;
- the threshold boundaries (counts exactly equal to 7600 and 9000);
- the doubling for a pre-divided input;
- the settling delay, bounded by the cycles from start to done.

The bench shortens the settling phase through its parameter to keep run time down.

// File: rtl/clk_gauge_pkg.sv
package clk_gauge_pkg;

  typedef enum logic [2:0] {
    FC_12M  = 3'd0,
    FC_13M  = 3'd1,
    FC_19M2 = 3'd2,
    FC_24M  = 3'd3,
    FC_26M  = 3'd4,
    FC_38M4 = 3'd5
  } freq_class_e;

  // strict lower bounds, window of 20 reference periods
  localparam int unsigned TH_38M4 = 19000;
  localparam int unsigned TH_26M  = 15200;
  localparam int unsigned TH_24M  = 13000;
  localparam int unsigned TH_19M2 = 9000;
  localparam int unsigned TH_13M  = 7600;

  typedef struct packed {
    freq_class_e cls;
    logic [2:0]  sel;
    logic        div2;
    logic [1:0]  idx;
    logic        clr_aux;
  } gauge_result_t;

endpackage

// File: rtl/cg_ref_sync.sv
module cg_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], ref_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  p_rise_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/cg_tick_cnt.sv
module cg_tick_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/cg_window_ctl.sv
module cg_window_ctl #(
  parameter int CNT_W          = 32,
  parameter int SETTLE_PERIODS = 20,
  parameter int WINDOW_PERIODS = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] tick_i,
  output logic [CNT_W-1:0] diff_o,
  output logic             diff_vld_o
);

  localparam int MAXP = (SETTLE_PERIODS > WINDOW_PERIODS) ? SETTLE_PERIODS : WINDOW_PERIODS;
  localparam int EW   = $clog2(MAXP + 1);
  localparam logic [EW-1:0] SET_LAST = EW'(SETTLE_PERIODS - 1);
  localparam logic [EW-1:0] WIN_LAST = EW'(WINDOW_PERIODS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_WINDOW} st_e;

  st_e              st_q;
  logic [EW-1:0]    edge_q;
  logic [CNT_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      edge_q     <= '0;
      base_q     <= '0;
      diff_o     <= '0;
      diff_vld_o <= 1'b0;
    end else begin
      diff_vld_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_SETTLE;
          edge_q <= '0;
        end
        ST_SETTLE: if (rise_i) begin
          if (edge_q == SET_LAST) begin
            base_q <= tick_i;
            edge_q <= '0;
            st_q   <= ST_WINDOW;
          end else begin
            edge_q <= edge_q + 1'b1;
          end
        end
        ST_WINDOW: if (rise_i) begin
          if (edge_q == WIN_LAST) begin
            diff_o     <= tick_i - base_q;
            diff_vld_o <= 1'b1;
            st_q       <= ST_IDLE;
          end else begin
            edge_q <= edge_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && start_i && !rise_i) |=> (st_q == $past(st_q) && edge_q == $past(edge_q)));

  p_vld_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_vld_o |=> !diff_vld_o);

endmodule

// File: rtl/cg_classify.sv
module cg_classify
  import clk_gauge_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] diff_i,
  input  logic             prediv2_i,
  output gauge_result_t    res_o
);

  localparam int SW = CNT_W + 1;

  logic [SW-1:0] scaled;
  freq_class_e   cls;
  logic [2:0]    sel;

  assign scaled = prediv2_i ? {diff_i, 1'b0} : {1'b0, diff_i};

  always_comb begin
    if      (scaled > SW'(TH_38M4)) cls = FC_38M4;
    else if (scaled > SW'(TH_26M))  cls = FC_26M;
    else if (scaled > SW'(TH_24M))  cls = FC_24M;
    else if (scaled > SW'(TH_19M2)) cls = FC_19M2;
    else if (scaled > SW'(TH_13M))  cls = FC_13M;
    else                            cls = FC_12M;
  end

  always_comb begin
    unique case (cls)
      FC_38M4: sel = 3'd4;
      FC_26M:  sel = 3'd3;
      FC_19M2: sel = 3'd2;
      FC_13M:  sel = 3'd1;
      default: sel = 3'd0;
    endcase
  end

  always_comb begin
    res_o.cls     = cls;
    res_o.sel     = sel;
    res_o.div2    = (sel > 3'd2);
    res_o.idx     = (sel > 3'd2) ? sel[2:1] : sel[1:0];
    res_o.clr_aux = (sel != 3'd1);
  end

endmodule

// File: rtl/clk_class_gauge.sv
module clk_class_gauge
  import clk_gauge_pkg::*;
#(
  parameter int CNT_W          = 32,
  parameter int SETTLE_PERIODS = 20,
  parameter int WINDOW_PERIODS = 20,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_clk_i,
  input  logic       start_i,
  input  logic       prediv2_i,
  output logic       done_o,
  output logic [2:0] class_o,
  output logic [2:0] sel_o,
  output logic       div2_o,
  output logic [1:0] index_o,
  output logic       clr_aux_div_o
);

  logic             ref_rise;
  logic [CNT_W-1:0] tick;
  logic [CNT_W-1:0] diff;
  logic             diff_vld;
  gauge_result_t    res_d, res_q;

  cg_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_clk_i), .rise_o(ref_rise));

  cg_tick_cnt #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_o(tick));

  cg_window_ctl #(
    .CNT_W(CNT_W), .SETTLE_PERIODS(SETTLE_PERIODS), .WINDOW_PERIODS(WINDOW_PERIODS)
  ) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rise_i(ref_rise),
    .tick_i(tick), .diff_o(diff), .diff_vld_o(diff_vld));

  cg_classify #(.CNT_W(CNT_W)) u_cls (
    .diff_i(diff), .prediv2_i(prediv2_i), .res_o(res_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= diff_vld;
      if (diff_vld) res_q <= res_d;
    end
  end

  assign class_o       = res_q.cls;
  assign sel_o         = res_q.sel;
  assign div2_o        = res_q.div2;
  assign index_o       = res_q.idx;
  assign clr_aux_div_o = res_q.clr_aux;

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(res_q));

  p_div_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (div2_o == (sel_o > 3'd2)));

  p_clr_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (clr_aux_div_o == (sel_o != 3'd1)));

endmodule

// File: tb/clk_class_gauge_test.sv
module clk_class_gauge_test;
  import clk_gauge_pkg::*;

  localparam int SETTLE = 4;
  localparam int WINDOW = 20;
  localparam int WDOG   = 195000;

  logic clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0, start = 1'b0, prediv = 1'b0;
  logic done;
  logic [2:0] cls, sel;
  logic div2, clr;
  logic [1:0] idx;

  int checks = 0, errors = 0, cycle = 0;
  int ref_half = 200;
  int start_cycle = 0;
  int dones = 0;
  bit finished = 0;

  gauge_result_t exp_q[$];
  int            per_q[$];
  gauge_result_t held;
  bit            have_held = 0;
  logic          prev_done = 1'b0;

  always #10 clk = ~clk;

  clk_class_gauge #(.SETTLE_PERIODS(SETTLE), .WINDOW_PERIODS(WINDOW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .start_i(start),
    .prediv2_i(prediv), .done_o(done), .class_o(cls), .sel_o(sel),
    .div2_o(div2), .index_o(idx), .clr_aux_div_o(clr));

  initial forever begin
    repeat (ref_half) @(negedge clk);
    ref_clk = ~ref_clk;
  end

  function automatic gauge_result_t expect_for(int period, bit pd);
    gauge_result_t e;
    longint d = longint'(WINDOW) * period * (pd ? 2 : 1);
    if      (d > 19000) begin e.cls = FC_38M4; e.sel = 3'd4; end
    else if (d > 15200) begin e.cls = FC_26M;  e.sel = 3'd3; end
    else if (d > 13000) begin e.cls = FC_24M;  e.sel = 3'd0; end
    else if (d > 9000)  begin e.cls = FC_19M2; e.sel = 3'd2; end
    else if (d > 7600)  begin e.cls = FC_13M;  e.sel = 3'd1; end
    else                begin e.cls = FC_12M;  e.sel = 3'd0; end
    e.div2    = (e.sel > 2);
    e.idx     = e.div2 ? 2'(e.sel / 2) : 2'(e.sel);
    e.clr_aux = (e.sel != 1);
    return e;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d @cycle %0d", req, act, exp, cycle);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    gauge_result_t e;
    int p, el;
    cycle++;
    if (rst_n) begin
      if (prev_done && done) chk(0, "R8 done width", 1, 0);
      if (done) begin
        dones++;
        if (exp_q.size() == 0) chk(0, "R8 unexpected done", 1, 0);
        else begin
          e = exp_q.pop_front();
          p = per_q.pop_front();
          el = cycle - start_cycle;
          chk(cls == e.cls, "R4 class", cls, e.cls);
          chk(sel == e.sel, "R5 sel", sel, e.sel);
          chk(div2 == e.div2, "R6 div2", div2, e.div2);
          chk(idx == e.idx, "R6 index", idx, e.idx);
          chk(clr == e.clr_aux, "R7 clr_aux", clr, e.clr_aux);
          chk(el >= (SETTLE + WINDOW - 1) * p, "R1 settle delay min", el, (SETTLE + WINDOW - 1) * p);
          chk(el <= (SETTLE + WINDOW) * p + 12, "R9 no restart max", el, (SETTLE + WINDOW) * p + 12);
        end
        held = {freq_class_e'(cls), sel, div2, idx, clr};
        have_held = 1;
      end else if (have_held && (cycle % 97 == 0)) begin
        chk({cls, sel, div2, idx, clr} == held, "R8 hold", {cls, sel, div2, idx, clr}, held);
      end
    end
    prev_done = done;
  end

  task automatic measure(int period, bit pd, bit restart);
    int old = ref_half * 2;
    int n = dones;
    ref_half = period / 2;
    prediv = pd;
    repeat (2 * ((old > period) ? old : period)) @(negedge clk);
    exp_q.push_back(expect_for(period, pd));
    per_q.push_back(period);
    start_cycle = cycle;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      repeat ((SETTLE + 5) * period) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (dones > n);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 0, "R10 done reset", done, 0);
    chk({cls, sel, div2, idx, clr} == '0, "R10 outputs reset", {cls, sel, div2, idx, clr}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(done == 0, "R10 done idle", done, 0);
    measure(380, 0, 0);   // R2 R4 count 7600, boundary -> 12 MHz
    measure(400, 0, 0);   // 8000 -> 13 MHz, R7 clr low
    measure(450, 0, 0);   // 9000 boundary -> 13 MHz
    measure(500, 0, 0);   // 10000 -> 19.2 MHz
    measure(700, 0, 0);   // 14000 -> 24 MHz, R5 sel 0
    measure(800, 0, 0);   // 16000 -> 26 MHz, R6 div2 index 1
    measure(1000, 0, 0);  // 20000 -> 38.4 MHz, index 2
    measure(226, 1, 0);   // R3 4520*2 -> 19.2 MHz
    measure(500, 1, 0);   // R3 10000*2 -> 38.4 MHz
    measure(400, 0, 1);   // R9 start during measurement
    chk(exp_q.size() == 0, "R8 all done seen", exp_q.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycle > WDOG);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycle, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule